// File: doc/BRIEF.md
# Half-Rate Horizontal Waveform Generator

This block generates the horizontal control signals of one raster scan line: a blanking level, a sync level, a pulse that marks the exact middle of the line (used by interlace timing), and a pulse on the last count of the line that a vertical sequencer can use to step its own state. The position counter advances once per `step_en` pulse. That enable runs at half the pixel rate, so each count covers two pixels. Every profile figure is given in pixels, must be even, and is halved inside the block.

A small set of waveform profiles is fixed by parameters. Each profile gives four values: the pixels in a whole line, the visible pixels, the pixels between the end of the visible region and the start of sync, and the sync width. The default set has three profiles. Index 0 is (760, 656, 14, 70). Index 1 and index 2 are both (1440, 1072, 10, 336). A select input chooses the profile for the next line, and the choice only takes effect when the line wraps. Profiles that would move blanking on an odd half-rate boundary, that cannot place the middle pulse exactly, or that leave too little blanking around sync are rejected when the design is elaborated.

Top module: `hwave_gen`

## Requirements
- R1: While `rst_n` is low and after it is released (until the first step), all four outputs are 0, the position is 0 and the active profile is index 0.
- R2: The position changes only in a cycle where `step_en` is 1. With `step_en` at 0, all outputs keep their values and both pulses are 0.
- R3: `hblank` is 1 exactly when the position p (counted in pixel pairs from 0) satisfies p >= visible/2. It falls when the line wraps to position 0.
- R4: `hsync` is 1 exactly when (visible+gap)/2 <= p < (visible+gap+sync)/2. It is never 1 while `hblank` is 0.
- R5: `half_line` is a one-cycle pulse in the cycle after the step that enters position total/4.
- R6: `line_end` is a one-cycle pulse in the cycle after the step that enters position total/2 - 1. The step taken at that position wraps the line to 0.
- R7: `prof_sel` is sampled only on the wrapping step and sets the profile of the line that follows. Defaults are index 0 = (760, 656, 14, 70) and indices 1 and 2 = (1440, 1072, 10, 336), given as (total, visible, gap, sync) in pixels.
- R8: A `prof_sel` value of NUM_PROF or more at the wrapping step is ignored, and the current profile is kept.
- R9: Every profile passes these checks at elaboration. All four values are even. The total and the visible count are multiples of 4. (total - visible - gap) mod 4 = 2. The gap is at least 10 pixels. The blanking after sync ends is at least 10 pixels. As a result, the port waveform shows at least 10 blank pixels before sync and after sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Half-pixel-rate count enable |
| prof_sel | input | 2 | Profile index for the next line |
| hblank | output | 1 | Horizontal blanking level |
| hsync | output | 1 | Horizontal sync level |
| half_line | output | 1 | Mid-line pulse |
| line_end | output | 1 | Last-count-of-line pulse |

## Verification
Whole lines are run in each profile with the enable on every other cycle. This shows whether the blanking, sync, mid-line and end positions are placed correctly for both the short and the long profile. A pattern with irregular gaps in the enable separates counting per enable from counting per clock. A select change in mid-line shows whether the profile switch waits for the wrap. An out-of-range select across a wrap shows whether invalid indices are ignored. The blank-before-sync and blank-after-sync widths are measured at the ports for each profile.

// File: rtl/hwave_pkg.sv
package hwave_pkg;

   localparam int LIM_W = 16;

   typedef logic [LIM_W-1:0] lim_t;

   // Per-profile decode limits, all in pixel pairs.
   typedef struct packed {
      lim_t last_pos;   // total/2 - 1
      lim_t blank_on;   // visible/2
      lim_t sync_on;    // (visible+gap)/2
      lim_t sync_off;   // (visible+gap+sync)/2, exclusive
      lim_t mid_pos;    // total/4
   } prof_lim_t;

   function automatic lim_t to_pairs(input int unsigned pixels);
      return lim_t'(pixels / 2);
   endfunction

endpackage

// File: rtl/hwave_profile_table.sv
module hwave_profile_table
   import hwave_pkg::*;
#(
   parameter int unsigned NUM_PROF = 3,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned MIN_PORCH = 10,
   parameter int unsigned PIX_TOTAL [NUM_PROF] = '{760, 1440, 1440},
   parameter int unsigned PIX_VIS   [NUM_PROF] = '{656, 1072, 1072},
   parameter int unsigned PIX_GAP   [NUM_PROF] = '{14, 10, 10},
   parameter int unsigned PIX_SYNC  [NUM_PROF] = '{70, 336, 336}
) (
   input  logic [SEL_W-1:0] act_idx,
   output prof_lim_t        lim
);

   prof_lim_t lim_tab [NUM_PROF];

   for (genvar i = 0; i < NUM_PROF; i++) begin : g_prof
      localparam int unsigned T = PIX_TOTAL[i];
      localparam int unsigned V = PIX_VIS[i];
      localparam int unsigned G = PIX_GAP[i];
      localparam int unsigned S = PIX_SYNC[i];

      assign lim_tab[i].last_pos = to_pairs(T) - lim_t'(1);
      assign lim_tab[i].blank_on = to_pairs(V);
      assign lim_tab[i].sync_on  = to_pairs(V + G);
      assign lim_tab[i].sync_off = to_pairs(V + G + S);
      assign lim_tab[i].mid_pos  = to_pairs(T / 2);

      // Profile legality, checked once at start-up (R9).
      initial begin
         p_even_r9: assert ((T % 2 == 0) && (V % 2 == 0) && (G % 2 == 0) && (S % 2 == 0))
            else $error("profile %0d has an odd value", i);
         p_total_mod4_r9: assert (T % 4 == 0)
            else $error("profile %0d total not a multiple of 4", i);
         p_vis_mod4_r9: assert (V % 4 == 0)
            else $error("profile %0d visible not a multiple of 4", i);
         p_front_mod4_r9: assert (T > V + G && (T - V - G) % 4 == 2)
            else $error("profile %0d blank edge on odd boundary", i);
         p_front_porch_r9: assert (G >= MIN_PORCH)
            else $error("profile %0d gap before sync too short", i);
         p_back_porch_r9: assert (T >= V + G + S + MIN_PORCH)
            else $error("profile %0d blank after sync too short", i);
         p_fits_r9: assert (T / 2 < (1 << LIM_W))
            else $error("profile %0d too long for limit width", i);
      end
   end

   always_comb begin
      lim = lim_tab[0];
      for (int k = 0; k < NUM_PROF; k++) begin
         if (act_idx == SEL_W'(k)) lim = lim_tab[k];
      end
   end

endmodule

// File: rtl/hwave_line_counter.sv
module hwave_line_counter
   import hwave_pkg::*;
#(
   parameter int unsigned NUM_PROF = 3,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [SEL_W-1:0] prof_sel,
   input  lim_t             last_pos,
   output logic [SEL_W-1:0] act_idx,
   output logic [CNT_W-1:0] nxt_pos
);

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] act_q;
   logic             wrap_go;
   logic             sel_ok;

   assign wrap_go = step_en && (lim_t'(cnt_q) == last_pos);
   assign sel_ok  = ({1'b0, prof_sel} < (SEL_W+1)'(NUM_PROF));

   always_comb begin
      nxt_pos = cnt_q;
      if (step_en) nxt_pos = wrap_go ? '0 : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else begin
         cnt_q <= nxt_pos;
         if (wrap_go && sel_ok) act_q <= prof_sel;
      end
   end

   assign act_idx = act_q;

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(cnt_q));
   p_prof_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(wrap_go));
   p_prof_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, act_q} < (SEL_W+1)'(NUM_PROF));

endmodule

// File: rtl/hwave_strobe_decode.sv
module hwave_strobe_decode
   import hwave_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [CNT_W-1:0] nxt_pos,
   input  prof_lim_t        lim,
   output logic             hblank,
   output logic             hsync,
   output logic             half_line,
   output logic             line_end
);

   lim_t pos_w;
   logic blank_q, sync_q, half_q, end_q;

   assign pos_w = lim_t'(nxt_pos);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blank_q <= 1'b0;
         sync_q  <= 1'b0;
         half_q  <= 1'b0;
         end_q   <= 1'b0;
      end else begin
         blank_q <= (pos_w >= lim.blank_on);
         sync_q  <= (pos_w >= lim.sync_on) && (pos_w < lim.sync_off);
         half_q  <= step_en && (pos_w == lim.mid_pos);
         end_q   <= step_en && (pos_w == lim.last_pos);
      end
   end

   assign hblank    = blank_q;
   assign hsync     = sync_q;
   assign half_line = half_q;
   assign line_end  = end_q;

   p_sync_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> blank_q);
   p_half_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      half_q |=> !half_q);
   p_end_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      end_q |=> !end_q);
   p_end_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      end_q |-> blank_q);

endmodule

// File: rtl/hwave_gen.sv
module hwave_gen
   import hwave_pkg::*;
#(
   parameter int unsigned NUM_PROF = 3,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned CNT_W = 10,
   parameter int unsigned MIN_PORCH = 10,
   parameter int unsigned PIX_TOTAL [NUM_PROF] = '{760, 1440, 1440},
   parameter int unsigned PIX_VIS   [NUM_PROF] = '{656, 1072, 1072},
   parameter int unsigned PIX_GAP   [NUM_PROF] = '{14, 10, 10},
   parameter int unsigned PIX_SYNC  [NUM_PROF] = '{70, 336, 336}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [SEL_W-1:0] prof_sel,
   output logic             hblank,
   output logic             hsync,
   output logic             half_line,
   output logic             line_end
);

   initial begin
      p_sel_width_r8: assert ((1 << SEL_W) >= NUM_PROF)
         else $error("select too narrow for profile count");
      p_cnt_width_r9: assert (CNT_W <= LIM_W)
         else $error("counter wider than limit type");
   end

   for (genvar i = 0; i < NUM_PROF; i++) begin : g_cnt_fit
      initial begin
         p_cnt_fit_r9: assert (PIX_TOTAL[i] / 2 <= (1 << CNT_W))
            else $error("profile %0d exceeds counter range", i);
      end
   end

   prof_lim_t        lim;
   logic [SEL_W-1:0] act_idx;
   logic [CNT_W-1:0] nxt_pos;

   hwave_profile_table #(
      .NUM_PROF (NUM_PROF),
      .SEL_W    (SEL_W),
      .MIN_PORCH(MIN_PORCH),
      .PIX_TOTAL(PIX_TOTAL),
      .PIX_VIS  (PIX_VIS),
      .PIX_GAP  (PIX_GAP),
      .PIX_SYNC (PIX_SYNC)
   ) u_table (
      .act_idx(act_idx),
      .lim    (lim)
   );

   hwave_line_counter #(
      .NUM_PROF(NUM_PROF),
      .SEL_W   (SEL_W),
      .CNT_W   (CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .prof_sel(prof_sel),
      .last_pos(lim.last_pos),
      .act_idx (act_idx),
      .nxt_pos (nxt_pos)
   );

   hwave_strobe_decode #(
      .CNT_W(CNT_W)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .nxt_pos  (nxt_pos),
      .lim      (lim),
      .hblank   (hblank),
      .hsync    (hsync),
      .half_line(half_line),
      .line_end (line_end)
   );

endmodule

// File: tb/hwave_gen_bench.sv
`timescale 1ns/1ps
module hwave_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_en = 1'b0;
   logic [1:0] prof_sel = 2'd0;
   logic       hblank, hsync, half_line, line_end;

   always #2 clk = ~clk;

   hwave_gen u_hwave_gen (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .prof_sel(prof_sel),
      .hblank(hblank), .hsync(hsync), .half_line(half_line), .line_end(line_end)
   );

   // Profile figures in pixels, taken from the requirements.
   int px_t [3] = '{760, 1440, 1440};
   int px_v [3] = '{656, 1072, 1072};
   int px_g [3] = '{14, 10, 10};
   int px_s [3] = '{70, 336, 336};

   int n_vec = 0;
   int n_bad = 0;
   int m_pos = 0;
   int m_prof = 0;
   bit m_wrapped;
   bit prev_blank, prev_sync;
   int blank_rise, sync_rise, sync_fall;

   task automatic check(input string tag, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (pos %0d prof %0d)", tag, got, exp, m_pos, m_prof);
      end
   endtask

   // One clock: drive at negedge, sample at the next negedge.
   task automatic step_cycle(input bit st, input logic [1:0] sel);
      int h;
      bit e_half, e_end;
      step_en = st;
      prof_sel = sel;
      @(posedge clk);
      @(negedge clk);
      e_half = 0; e_end = 0; m_wrapped = 0;
      h = px_t[m_prof] / 2;
      if (st) begin
         if (m_pos == h - 1) begin
            m_pos = 0; m_wrapped = 1;
            if (sel < 3) m_prof = sel;
         end else m_pos++;
         if (m_pos == px_t[m_prof] / 4) e_half = 1;
         if (m_pos == px_t[m_prof] / 2 - 1) e_end = 1;
      end
      check("R3 hblank", hblank, m_pos >= px_v[m_prof] / 2);
      check("R4 hsync", hsync, (m_pos >= (px_v[m_prof] + px_g[m_prof]) / 2) &&
            (m_pos < (px_v[m_prof] + px_g[m_prof] + px_s[m_prof]) / 2));
      check("R5 half_line", half_line, e_half);
      check("R6 line_end", line_end, e_end);
      if (hblank && !prev_blank) blank_rise = m_pos;
      if (hsync && !prev_sync) sync_rise = m_pos;
      if (!hsync && prev_sync) sync_fall = m_pos;
      prev_blank = hblank;
      prev_sync = hsync;
   endtask

   // Run steps on alternate clocks until the model wraps.
   task automatic run_to_wrap(input logic [1:0] sel);
      m_wrapped = 0;
      while (!m_wrapped) begin
         step_cycle(1'b0, sel);
         step_cycle(1'b1, sel);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 hblank in reset", hblank, 0);
      check("R1 hsync in reset", hsync, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 hblank after reset", hblank, 0);
      check("R1 hsync after reset", hsync, 0);
      check("R1 half_line after reset", half_line, 0);
      check("R1 line_end after reset", line_end, 0);
      m_pos = 0; m_prof = 0; prev_blank = 0; prev_sync = 0;
   endtask

   // Whole line in profile p and porch measurement at the ports.
   task automatic t_full_line(input int p);
      run_to_wrap(2'(p));
      run_to_wrap(2'(p));
      check("R7 active profile", m_prof, p);
      check("R9 even blank edge", (blank_rise * 2) % 4, 0);
      check("R9 blank before sync", ((sync_rise - blank_rise) * 2 >= 10) ? 1 : 0, 1);
      check("R9 blank after sync", ((px_t[p] / 2 - sync_fall) * 2 >= 10) ? 1 : 0, 1);
      check("R3 blank rise pos", blank_rise, px_v[p] / 2);
   endtask

   // Irregular enable; outputs must stay still while idle.
   task automatic t_stall;
      logic b0, s0;
      for (int i = 0; i < 900; i++) begin
         step_cycle((i % 5 == 0) || (i % 7 == 3), 2'd0);
         b0 = hblank; s0 = hsync;
         if (i % 50 == 0) begin
            for (int j = 0; j < 6; j++) step_cycle(1'b0, 2'd0);
            check("R2 blank held idle", hblank, b0);
            check("R2 sync held idle", hsync, s0);
            check("R2 no pulse idle", half_line | line_end, 0);
         end
      end
   endtask

   // Select changed in mid-line applies only at the wrap.
   task automatic t_switch;
      run_to_wrap(2'd0);
      for (int i = 0; i < 100; i++) begin
         step_cycle(1'b0, 2'd1);
         step_cycle(1'b1, 2'd1);
      end
      check("R7 no switch mid-line", m_prof, 0);
      run_to_wrap(2'd1);
      run_to_wrap(2'd1);
      check("R7 switched after wrap", blank_rise, px_v[1] / 2);
   endtask

   // Out-of-range select across a wrap keeps the profile.
   task automatic t_invalid;
      run_to_wrap(2'd3);
      run_to_wrap(2'd3);
      check("R8 profile kept", m_prof, 1);
      check("R8 blank rise unchanged", blank_rise, px_v[1] / 2);
      run_to_wrap(2'd0);
      run_to_wrap(2'd0);
      check("R8 valid select after", blank_rise, px_v[0] / 2);
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_full_line(0);
      t_stall();
      t_full_line(2);
      t_full_line(0);
      t_switch();
      t_invalid();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule